// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a serial slave that gives a host read and write access to a bank of byte-wide configuration registers. The host frames each transfer with an enable line. While enable is high it clocks bits in on a serial clock. The block samples all three serial lines on its own system clock, so the host's serial clock must run several times slower than that clock. The first byte of a transfer is a header that holds a direction flag and a 7-bit register address. Each later byte reads or writes the next register in turn. This lets one header cover a contiguous range of registers.

The active serial clock edge is not fixed. At each rising edge of enable the block records the level of the serial clock line. A high level selects rising-edge transfer for that framed access, and a low level selects falling-edge transfer. Bit 0 of a control register picks the wiring. When it is clear, one data pin carries write data in and read data out (3-wire). When it is set, the data pin is input-only and a separate output pin returns read data (4-wire). Tristate control appears as output-enable signals. A write to one dedicated command address does not store anything. Instead it raises a one-cycle start strobe for a transmit command, together with the written byte.

Top module: `cfg_spi_slave`

## Requirements
- R1: While `en` is low, serial clock and data activity change no register and produce no strobe.
- R2: At each rising edge of `en` the level of `sck` is latched. A high level makes rising `sck` edges the active edges for that transfer, and a low level makes falling edges active. Bits are sampled from `sdio_in` on active edges only.
- R3: All bytes are sent most significant bit first. The first byte of a transfer is the header: bit 7 set means read and clear means write, and bits 6:0 are the register address.
- R4: Each data byte after the header targets the address of the previous byte plus one (auto-increment), for both reads and writes.
- R5: If `en` falls before a byte is complete, the partial byte is discarded and nothing is written. The next transfer starts again with a fresh header.
- R6: In 3-wire mode a read drives `sdio_out` with `sdio_oe` high, MSB first, starting only after the header is complete. `sdio_oe` is low during the header, and it drops as soon as `en` goes low.
- R7: In 4-wire mode (bit 0 of register `CTRL_ADDR` = 1) read data appears on `sdo_out` with `sdo_oe` high and `sdio_oe` stays low. `sdo_oe` stays low until read data is driven after the header. The two output enables are never high together.
- R8: Writes to addresses at or above `NREG` (other than the command address) are ignored, and reads from them return 0x00.
- R9: A write of byte B to address `CMD_ADDR` (default 0x7F) pulses `tx_go` high for exactly one clock, with `tx_cmd` = B.
- R10: After reset all registers read 0x00, both output enables are low and `tx_go` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; serial lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Transfer framing enable, active high |
| sck | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Serial data into the block |
| sdio_out | output | 1 | Read data for the bidirectional pin |
| sdio_oe | output | 1 | Drive enable for the bidirectional pin (3-wire reads) |
| sdo_out | output | 1 | Read data for the separate output pin |
| sdo_oe | output | 1 | Drive enable for the separate output pin (4-wire reads) |
| regs_o | output | NREG*8 | All register contents, register n at bits [8n+7:8n] |
| tx_go | output | 1 | One-cycle transmit command strobe |
| tx_cmd | output | 8 | Byte written with the last transmit command |

## Verification
A register write lands on the system clock edge that first sees the eighth active serial edge of a data byte. A read bit, or a reloaded read byte, is valid one system clock after the active edge that shifts it out. The output enables follow `en` with no delay. The bench holds each serial clock level for two system clocks and drives inputs on the falling system edge. It samples read data and enables just before each active serial edge, and checks registers and strobes only after the transfer has ended. This way every check falls at least one full cycle after the result is due.

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave #(
  parameter int NREG      = 16,
  parameter int CTRL_ADDR = 0,
  parameter int CMD_ADDR  = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sck,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo_out,
  output logic              sdo_oe,
  output logic [NREG*8-1:0] regs_o,
  output logic              tx_go,
  output logic [7:0]        tx_cmd
);

  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [6:0]    LAST = 7'(NREG - 1);
  localparam logic [6:0]    CMD  = 7'(CMD_ADDR);
  localparam logic [AW-1:0] CTRL = AW'(CTRL_ADDR);

  logic       en_q, sck_q, pol, hdr_done, rd;
  logic [2:0] cnt;
  logic [7:0] sh, tx_sh;
  logic [6:0] addr;
  logic [7:0] regs [NREG];

  function automatic logic [7:0] rdata(input logic [6:0] a);
    return (a <= LAST) ? regs[a[AW-1:0]] : 8'h00;
  endfunction

  wire       four_wire = regs[CTRL][0];
  wire       act       = en && en_q && (pol ? (sck && !sck_q) : (!sck && sck_q));
  wire [7:0] sh_n      = {sh[6:0], sdio_in};
  wire       byte_end  = act && (cnt == 3'd7);
  wire [6:0] addr_nx   = addr + 7'd1;
  wire       wr_hit    = byte_end && hdr_done && !rd && (addr <= LAST);

  assign sdio_out = tx_sh[7];
  assign sdo_out  = tx_sh[7];
  assign sdio_oe  = en && hdr_done && rd && !four_wire;
  assign sdo_oe   = en && hdr_done && rd && four_wire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; sck_q <= 1'b0; pol <= 1'b0;
      hdr_done <= 1'b0; rd <= 1'b0; cnt <= '0;
      sh <= '0; tx_sh <= '0; addr <= '0;
      tx_go <= 1'b0; tx_cmd <= '0;
    end else begin
      en_q  <= en;
      sck_q <= sck;
      tx_go <= 1'b0;
      if (en && !en_q) pol <= sck;
      if (!en) begin
        cnt <= '0; hdr_done <= 1'b0; rd <= 1'b0;
      end else if (act) begin
        cnt   <= cnt + 3'd1;
        sh    <= sh_n;
        tx_sh <= {tx_sh[6:0], 1'b0};
        if (byte_end) begin
          if (!hdr_done) begin
            hdr_done <= 1'b1;
            rd       <= sh_n[7];
            addr     <= sh_n[6:0];
            tx_sh    <= rdata(sh_n[6:0]);
          end else begin
            addr <= addr_nx;
            if (rd) tx_sh <= rdata(addr_nx);
            else if (addr == CMD) begin
              tx_go  <= 1'b1;
              tx_cmd <= sh_n;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
    end else if (wr_hit) begin
      regs[addr[AW-1:0]] <= sh_n;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(regs_o)); // R1
  AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_q) |=> $stable(pol)); // R2
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == 3'd0) && !hdr_done); // R5
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !tx_go); // R9
  AST_GO_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> $past(en)); // R9
  AST_OE_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdio_oe && sdo_oe)); // R7

endmodule

// File: tb/cfg_spi_slave_tb.sv
module cfg_spi_slave_tb;
  localparam int CLK_P = 10;
  localparam int NREG  = 16;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, sck = 1'b0, sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo_out, sdo_oe, tx_go;
  logic [NREG*8-1:0] regs_o;
  logic [7:0] tx_cmd;

  cfg_spi_slave #(.NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sck(sck), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .regs_o(regs_o), .tx_go(tx_go), .tx_cmd(tx_cmd));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nfail = 0, go_cnt = 0;
  logic [7:0] last_cmd = 8'h00;
  logic [7:0] exp_q[$];
  logic [7:0] obs_byte;
  string rd_tag = "R3";
  event got;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(got) begin
    logic [7:0] e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    chk(obs_byte === e, rd_tag, obs_byte, e);
  end

  always @(negedge clk) if (tx_go) begin go_cnt++; last_cmd = tx_cmd; end

  task automatic start(input bit pol);
    sck = pol;
    @(negedge clk); en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic stop();
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bitx(input bit pol, input bit d, input bit fw, output bit o);
    sdio_in = d; sck = !pol;
    repeat (2) @(negedge clk);
    o = fw ? sdo_out : sdio_out;
    sck = pol;
    repeat (2) @(negedge clk);
  endtask

  task automatic sbyte(input bit pol, input logic [7:0] b, input bit fw, output logic [7:0] o);
    for (int i = 7; i >= 0; i--) begin
      bit t;
      bitx(pol, b[i], fw, t);
      o[i] = t;
    end
  endtask

  task automatic wr(input bit pol, input logic [6:0] a, input logic [7:0] d[$]);
    logic [7:0] o;
    start(pol);
    sbyte(pol, {1'b0, a}, 1'b0, o);
    foreach (d[k]) sbyte(pol, d[k], 1'b0, o);
    stop();
  endtask

  task automatic rdx(input bit pol, input logic [6:0] a, input int n, input bit fw);
    logic [7:0] o;
    start(pol);
    sbyte(pol, {1'b1, a}, fw, o);
    for (int k = 0; k < n; k++) begin
      logic [7:0] hd;
      sbyte(pol, 8'h00, fw, hd);
      obs_byte = hd;
      -> got;
      #1;
    end
    chk(sdio_oe === !fw, "R6 sdio_oe in data phase", sdio_oe, !fw);
    chk(sdo_oe === fw, "R7 sdo_oe in data phase", sdo_oe, fw);
    stop();
    chk(sdio_oe === 1'b0 && sdo_oe === 1'b0, "R6 oe released on en low", {sdio_oe, sdo_oe}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [NREG*8-1:0] snap;
    logic [7:0] o;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(regs_o === '0, "R10 regs after reset", regs_o[63:0], 0);
    chk(!sdio_oe && !sdo_oe && !tx_go, "R10 outputs after reset", {sdio_oe, sdo_oe, tx_go}, 0);

    wr(1'b1, 7'd1, '{8'hA5});
    chk(regs_o[8 +: 8] === 8'hA5, "R2 R3 rising-edge write", regs_o[8 +: 8], 8'hA5);

    wr(1'b0, 7'd2, '{8'h11, 8'h22, 8'h33});
    chk(regs_o[16 +: 8] === 8'h11, "R2 falling-edge write", regs_o[16 +: 8], 8'h11);
    chk(regs_o[24 +: 8] === 8'h22, "R4 auto-increment byte 2", regs_o[24 +: 8], 8'h22);
    chk(regs_o[32 +: 8] === 8'h33, "R4 auto-increment byte 3", regs_o[32 +: 8], 8'h33);

    rd_tag = "R6 R4 3-wire read";
    exp_q.push_back(8'hA5); exp_q.push_back(8'h11); exp_q.push_back(8'h22);
    start(1'b1);
    sbyte(1'b1, 8'h81, 1'b0, o);
    stop();
    rdx(1'b1, 7'd1, 3, 1'b0);
    rd_tag = "R2 falling-edge read";
    exp_q.push_back(8'h33);
    rdx(1'b0, 7'd4, 1, 1'b0);

    start(1'b1);
    sbyte(1'b1, 8'h81, 1'b0, o);
    for (int i = 0; i < 3; i++) begin bit t; bitx(1'b1, 1'b1, 1'b0, t); end
    chk(sdio_oe === 1'b1, "R6 oe high after header", sdio_oe, 1);
    stop();

    start(1'b1);
    for (int i = 0; i < 5; i++) begin bit t; bitx(1'b1, 1'b1, 1'b0, t); end
    chk(sdio_oe === 1'b0, "R6 oe low during header", sdio_oe, 0);
    stop();

    start(1'b1);
    sbyte(1'b1, 8'h05, 1'b0, o);
    for (int i = 0; i < 4; i++) begin bit t; bitx(1'b1, 1'b1, 1'b0, t); end
    stop();
    chk(regs_o[40 +: 8] === 8'h00, "R5 partial data byte dropped", regs_o[40 +: 8], 0);
    start(1'b0);
    for (int i = 0; i < 3; i++) begin bit t; bitx(1'b0, 1'b1, 1'b0, t); end
    stop();
    wr(1'b0, 7'd6, '{8'h6C});
    chk(regs_o[48 +: 8] === 8'h6C, "R5 fresh header after partial", regs_o[48 +: 8], 8'h6C);

    snap = regs_o;
    for (int i = 0; i < 16; i++) begin bit t; bitx(1'b1, i[0], 1'b0, t); end
    chk(regs_o === snap && go_cnt == 0, "R1 no effect while en low", regs_o[63:0], snap[63:0]);

    wr(1'b1, 7'h20, '{8'hEE, 8'hDD});
    chk(regs_o === snap, "R8 out-of-range write ignored", regs_o[63:0], snap[63:0]);
    rd_tag = "R8 out-of-range read";
    exp_q.push_back(8'h00);
    rdx(1'b1, 7'h20, 1, 1'b0);

    wr(1'b1, 7'h7F, '{8'h5A});
    chk(go_cnt == 1, "R9 tx_go pulse count", go_cnt, 1);
    chk(last_cmd === 8'h5A, "R9 tx_cmd value", last_cmd, 8'h5A);

    wr(1'b0, 7'd0, '{8'h01});
    start(1'b1);
    sbyte(1'b1, 8'h81, 1'b1, o);
    chk(sdo_oe === 1'b1 && sdio_oe === 1'b0, "R7 4-wire oe after header", {sdio_oe, sdo_oe}, 1);
    stop();
    start(1'b1);
    for (int i = 0; i < 4; i++) begin bit t; bitx(1'b1, 1'b1, 1'b1, t); end
    chk(sdo_oe === 1'b0, "R7 sdo high-z during header", sdo_oe, 0);
    stop();
    rd_tag = "R7 4-wire read";
    exp_q.push_back(8'h01); exp_q.push_back(8'hA5);
    rdx(1'b1, 7'd0, 2, 1'b1);

    chk(exp_q.size() == 0, "R3 all reads compared", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule